// File: doc/BRIEF.md
# Single-Pattern Output Lock

This block wraps a small combinational function with one protected output bit. The function is a placeholder: the XOR-reduction (parity) of the whole primary input. The wrapper compares the low key-width bits of the input with a key input. When they match and the key is not the built-in correct key, a flip signal inverts the function output. With the correct key applied, the block behaves exactly like the bare function.

With any wrong key, only the input patterns whose compared slice equals that key are corrupted. As a result, one observed input pattern can rule out at most one wrong key. The correct key and the widths are fixed at elaboration time. A key wider than the input is rejected at elaboration.

The block is purely combinational and has no clock or reset. The output follows the inputs within one evaluation.

Top module: `opf_lock`

## Requirements
- R1: When `in_data[KEY_W-1:0]` equals `key_in` and `key_in` differs from `GOOD_KEY`, `out_prot` is the inverse of the XOR of all bits of `in_data`.
- R2: When `in_data[KEY_W-1:0]` differs from `key_in`, `out_prot` equals the XOR of all bits of `in_data`, whatever the upper input bits hold.
- R3: With `key_in` equal to `GOOD_KEY` (default 3'b101), `out_prot` equals the input parity for every one of the 2^IN_W input patterns.
- R4: For every wrong key, exactly 2^(IN_W-KEY_W) input patterns give a corrupted output (8 of 64 with the defaults).
- R5: An input whose low KEY_W bits equal `GOOD_KEY` is never corrupted, under any key.
- R6: Over all input and key combinations, the number of corrupted entries is (2^KEY_W-1)·2^(IN_W-KEY_W), which is 56 of 512 with the defaults.
- R7: The output is a pure function of the present inputs. With both inputs at zero and the default correct key, `out_prot` is 1, because key 0 is wrong and matches slice 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| in_data | input | IN_W | Primary input word; its low KEY_W bits are compared with the key |
| key_in | input | KEY_W | Applied unlock key |
| out_prot | output | 1 | Protected output: input parity, possibly inverted |

## Verification
The hardest situation to reach is the one that separates a wrong key from the correct one. Only one input slice in 2^KEY_W exposes a wrong key, so scattered stimulus almost never finds the corrupted entries. The bench therefore sweeps every input pattern for every key and counts the mismatches per key. It also counts the mismatches on the inputs whose slice equals the correct key. A short vector table checks the two masking conditions one at a time.

// File: rtl/opf_lock.sv
module opf_lock #(
  parameter int IN_W  = 6,
  parameter int KEY_W = 3,
  parameter logic [KEY_W-1:0] GOOD_KEY = 3'b101
) (
  input  logic [IN_W-1:0]  in_data,
  input  logic [KEY_W-1:0] key_in,
  output logic             out_prot
);

  generate
    if (KEY_W > IN_W || KEY_W < 1) begin : g_bad_width
      $error("opf_lock: key width must be between 1 and input width");
    end
  endgenerate

  logic base_fn;
  logic slice_hit;
  logic key_wrong;
  logic flip;

  assign base_fn   = ^in_data;
  assign slice_hit = (in_data[KEY_W-1:0] == key_in);
  assign key_wrong = (key_in != GOOD_KEY);
  assign flip      = slice_hit & key_wrong;
  assign out_prot  = base_fn ^ flip;

endmodule

// File: rtl/opf_lock_chk.sv
module opf_lock_chk #(
  parameter int IN_W  = 6,
  parameter int KEY_W = 3,
  parameter logic [KEY_W-1:0] GOOD_KEY = 3'b101
) (
  input logic [IN_W-1:0]  in_data,
  input logic [KEY_W-1:0] key_in,
  input logic             out_prot
);

  always_comb begin
    // R1
    wrong_match_flips_chk: assert (!((in_data[KEY_W-1:0] == key_in) && (key_in != GOOD_KEY))
                                   || (out_prot != ^in_data))
      else $error("R1: wrong key on matching slice did not invert");
    // R2
    no_match_clean_chk: assert ((in_data[KEY_W-1:0] == key_in) || (out_prot == ^in_data))
      else $error("R2: corruption without slice match");
    // R3
    good_key_clean_chk: assert ((key_in != GOOD_KEY) || (out_prot == ^in_data))
      else $error("R3: corruption under correct key");
    // R5
    good_slice_safe_chk: assert ((in_data[KEY_W-1:0] != GOOD_KEY) || (out_prot == ^in_data))
      else $error("R5: correct-key slice corrupted");
  end

endmodule

bind opf_lock opf_lock_chk #(.IN_W(IN_W), .KEY_W(KEY_W), .GOOD_KEY(GOOD_KEY)) u_chk (
  .in_data(in_data),
  .key_in(key_in),
  .out_prot(out_prot)
);

// File: tb/opf_lock_tb.sv
module opf_lock_tb;
  localparam int IN_W  = 6;
  localparam int KEY_W = 3;
  localparam logic [KEY_W-1:0] GOOD_KEY = 3'b101;
  localparam int N_IN  = 1 << IN_W;
  localparam int N_KEY = 1 << KEY_W;
  localparam int PER_KEY = 1 << (IN_W - KEY_W);

  // {in_data, key_in, expected}
  localparam logic [9:0] VEC [8] = '{
    {6'b000000, 3'd0, 1'b1},
    {6'b000101, 3'd5, 1'b0},
    {6'b110101, 3'd5, 1'b0},
    {6'b111011, 3'd3, 1'b0},
    {6'b111011, 3'd2, 1'b1},
    {6'b100111, 3'd7, 1'b1},
    {6'b000001, 3'd0, 1'b1},
    {6'b010010, 3'd2, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IN_W-1:0]  in_data = '0;
  logic [KEY_W-1:0] key_in  = '0;
  logic             out_prot;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  opf_lock #(.IN_W(IN_W), .KEY_W(KEY_W), .GOOD_KEY(GOOD_KEY)) u_dut (
    .in_data(in_data),
    .key_in(key_in),
    .out_prot(out_prot)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [IN_W-1:0] d, input logic [KEY_W-1:0] k);
    @(negedge clk);
    in_data = d;
    key_in  = k;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int all_bad;
    int safe_bad;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R7: zero inputs, key 0 is wrong and matches slice 0
    check("R7 zero inputs", int'(out_prot), 1);

    // R1 R2 R3: table walk
    foreach (VEC[i]) begin
      apply(VEC[i][9:4], VEC[i][3:1]);
      check("R1/R2/R3 vector", int'(out_prot), int'(VEC[i][0]));
    end

    // R4 R3 R5 R6: exhaustive sweep
    all_bad  = 0;
    safe_bad = 0;
    for (int k = 0; k < N_KEY; k++) begin
      int per;
      per = 0;
      for (int d = 0; d < N_IN; d++) begin
        logic [IN_W-1:0] dv;
        dv = IN_W'(d);
        apply(dv, KEY_W'(k));
        if (out_prot != ^dv) begin
          per++;
          if (dv[KEY_W-1:0] == GOOD_KEY) safe_bad++;
        end
      end
      all_bad += per;
      if (KEY_W'(k) == GOOD_KEY) check("R3 correct key count", per, 0);
      else                        check("R4 wrong key count", per, PER_KEY);
    end
    check("R5 good slice corruptions", safe_bad, 0);
    check("R6 total corruptions", all_bad, (N_KEY - 1) * PER_KEY);

    // R2: upper bits do not trigger the flip
    apply(6'b111000, 3'd1);
    check("R2 upper bits only", int'(out_prot), 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule